// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter

A small reversible counter with a compile-time choice of modulus: sixteen for plain binary counting or ten for decimal (BCD) counting. Every state bit changes on the same rising clock edge, so the outputs never show the intermediate codes that a ripple counter produces. Counting needs the active-low enable. A direction input picks increment or decrement.

An active-low load copies the data word into the state at once, without waiting for a clock edge, and it overrides counting. This lets the counter divide by an arbitrary N. For chaining, the block has two outputs. One is an active-high terminal flag that marks the last state in the current direction. The other is an active-low ripple pulse that covers the low half of the clock period in which the counter is about to wrap. Feeding that pulse to the clock pin of a second stage makes the second stage advance on the same rising edge where the first stage wraps.

Top module: `updn_counter`

## Requirements
- R1: While cnt_en_n is 1 at a rising clock edge and load_n stays 1, the count is unchanged.
- R2: With cnt_en_n = 0 and dir_dn = 0, each rising edge adds one; in binary mode (MODULUS = 16) the value 15 is followed by 0.
- R3: With cnt_en_n = 0 and dir_dn = 1, each rising edge subtracts one; the value 0 is followed by MODULUS-1 (15 in binary, 9 in decimal).
- R4: While load_n is 0, din appears on q at once, independent of the clock level, and a rising edge during that time leaves q equal to din whatever the enable and direction inputs are.
- R5: In decimal mode (MODULUS = 10), counting up runs 7, 8, 9, 0, 1, 2, and counting down runs 2, 1, 0, 9, 8, 7.
- R6: term_cnt is 1 exactly when q = MODULUS-1 with dir_dn = 0, or q = 0 with dir_dn = 1. It follows a change of dir_dn without a clock edge.
- R7: ripple_n is 0 only while clk is 0, term_cnt is 1 and cnt_en_n is 0. Otherwise it is 1, so its low time equals the clock's low phase.
- R8: In decimal mode, a loaded value from 10 to 15 goes to 0 on the next enabled up-count and to the value minus one on the next enabled down-count.
- R9: When ripple_n of one stage drives the clock of a second stage, the second stage moves one step in the shared direction on the same rising edge where the first stage wraps, giving carry and borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous parallel load, active low |
| din | input | W | Preset value (W = clog2(MODULUS)) |
| q | output | W | Current count |
| term_cnt | output | 1 | Terminal state for the present direction, active high |
| ripple_n | output | 1 | Gated low pulse for cascading, active low |

## Verification
The hardest conditions to reach are an asynchronous load in the middle of a clock period, and a change of direction that raises or drops the terminal flag between edges. The bench drives both from the high phase of the clock and observes q and term_cnt before the next edge arrives. It also loads decimal values above nine to reach the out-of-range recovery. It chains a second decimal stage clocked by the first stage's ripple_n, so that carries and borrows happen under random enable and direction patterns, and compares both stages against a bench model.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/updn_next.sv
module updn_next #(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = $clog2(MODULUS)
) (
    input  logic [W-1:0]     cnt_q,
    input  logic             en_n,
    input  updn_pkg::dir_e   dir,
    output logic [W-1:0]     cnt_d
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    logic [W-1:0] up_v;
    logic [W-1:0] dn_v;

    generate
        if (MODULUS == (1 << W)) begin : g_pow2
            assign up_v = cnt_q + W'(1);
            assign dn_v = cnt_q - W'(1);
        end else begin : g_mod
            // values above TOP fall back to zero going up
            assign up_v = (cnt_q >= TOP) ? '0 : cnt_q + W'(1);
            assign dn_v = (cnt_q == '0) ? TOP : cnt_q - W'(1);
        end
    endgenerate

    always_comb begin
        if (en_n)
            cnt_d = cnt_q;
        else if (dir == updn_pkg::DIR_DOWN)
            cnt_d = dn_v;
        else
            cnt_d = up_v;
    end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = $clog2(MODULUS)
) (
    input  logic [W-1:0]   cnt_q,
    input  updn_pkg::dir_e dir,
    output logic           term
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    always_comb begin
        if (dir == updn_pkg::DIR_DOWN)
            term = (cnt_q == '0);
        else
            term = (cnt_q == TOP);
    end
endmodule

// File: rtl/updn_ripple.sv
module updn_ripple (
    input  logic clk,
    input  logic term,
    input  logic en_n,
    output logic ripple_n
);
    always_comb ripple_n = ~(term & ~en_n & ~clk);
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
    parameter int unsigned MODULUS = 10,
    localparam int unsigned W      = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         cnt_en_n,
    input  logic         dir_dn,
    input  logic         load_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         term_cnt,
    output logic         ripple_n
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t          st_d;
    state_t          st_q;
    logic [W-1:0]    cnt_nx;
    updn_pkg::dir_e  dir;

    assign dir = updn_pkg::dir_e'(dir_dn);

    updn_next #(.MODULUS(MODULUS), .W(W)) next_i (
        .cnt_q (st_q.cnt),
        .en_n  (cnt_en_n),
        .dir   (dir),
        .cnt_d (cnt_nx)
    );

    updn_term #(.MODULUS(MODULUS), .W(W)) term_i (
        .cnt_q (st_q.cnt),
        .dir   (dir),
        .term  (term_cnt)
    );

    updn_ripple ripple_i (
        .clk      (clk),
        .term     (term_cnt),
        .en_n     (cnt_en_n),
        .ripple_n (ripple_n)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nx;
    end

    // load acts on its falling edge and holds the preset across clock edges
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)
            st_q <= '{cnt: din};
        else
            st_q <= st_d;
    end

    assign q = st_q.cnt;

    // ---------------- assertions ----------------
    logic armed_q;
    logic ld_seen_q;

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) armed_q <= 1'b1;
        else         armed_q <= armed_q;
    end

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) ld_seen_q <= 1'b1;
        else         ld_seen_q <= 1'b0;
    end

    a_r1_hold: assert property (@(posedge clk) disable iff (!armed_q || !load_n)
        cnt_en_n |=> ($stable(q) || ld_seen_q));

    a_r2_up_step: assert property (@(posedge clk) disable iff (!armed_q || !load_n)
        (!cnt_en_n && !dir_dn && q < TOP) |=> ((q == $past(q) + W'(1)) || ld_seen_q));

    a_r3_down_step: assert property (@(posedge clk) disable iff (!armed_q || !load_n)
        (!cnt_en_n && dir_dn && q != '0 && q <= TOP) |=> ((q == $past(q) - W'(1)) || ld_seen_q));

    a_r5_wrap_up: assert property (@(posedge clk) disable iff (!armed_q || !load_n)
        (!cnt_en_n && !dir_dn && q == TOP) |=> ((q == '0) || ld_seen_q));

    a_r5_wrap_down: assert property (@(posedge clk) disable iff (!armed_q || !load_n)
        (!cnt_en_n && dir_dn && q == '0) |=> ((q == TOP) || ld_seen_q));

    a_r4_load_wins: assert property (@(posedge clk) disable iff (!armed_q)
        (!load_n && $past(!load_n) && $stable(din)) |-> (q == din));

    a_r6_term_decode: assert property (@(posedge clk) disable iff (!armed_q)
        term_cnt == (dir_dn ? (q == '0) : (q == TOP)));

    a_r7_ripple_idle_high: assert property (@(negedge clk) disable iff (!armed_q)
        ripple_n);

endmodule

// File: tb/updn_counter_tb_top.sv
`timescale 1ns/100ps
module updn_counter_tb_top;
    logic       clk = 1'b0;
    logic       cnt_en_n = 1'b1;
    logic       dir_dn = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] din_lo = '0;
    logic [3:0] din_hi = '0;
    logic [3:0] din_bin = '0;

    logic [3:0] q_lo, q_hi, q_bin;
    logic       tc_lo, tc_hi, tc_bin;
    logic       rp_lo, rp_hi, rp_bin;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int m_lo, m_hi, m_bin;

    always #2 clk = ~clk;

    updn_counter #(.MODULUS(10)) dut_i (
        .clk(clk), .cnt_en_n(cnt_en_n), .dir_dn(dir_dn), .load_n(load_n),
        .din(din_lo), .q(q_lo), .term_cnt(tc_lo), .ripple_n(rp_lo));

    updn_counter #(.MODULUS(10)) dut_hi (
        .clk(rp_lo), .cnt_en_n(1'b0), .dir_dn(dir_dn), .load_n(load_n),
        .din(din_hi), .q(q_hi), .term_cnt(tc_hi), .ripple_n(rp_hi));

    updn_counter #(.MODULUS(16)) dut_bin (
        .clk(clk), .cnt_en_n(cnt_en_n), .dir_dn(dir_dn), .load_n(load_n),
        .din(din_bin), .q(q_bin), .term_cnt(tc_bin), .ripple_n(rp_bin));

    function automatic int nxt(int v, bit d, int m);
        if (!d) return (v >= m - 1) ? 0 : v + 1;
        return (v == 0) ? m - 1 : v - 1;
    endfunction

    function automatic bit tc_of(int v, bit d, int m);
        return d ? (v == 0) : (v == m - 1);
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_q(string req);
        check(req, q_lo, m_lo);
        check(req, q_hi, m_hi);
        check(req, q_bin, m_bin);
    endtask

    // called at posedge+1; applies a load pulse inside the high phase
    task automatic do_load(int lo, int hi, int bn);
        din_lo = 4'(lo); din_hi = 4'(hi); din_bin = 4'(bn);
        load_n = 1'b0;
        #0.4;
        m_lo = lo; m_hi = hi; m_bin = bn;
        check_q("R4 async load mid-period");
        load_n = 1'b1;
        #0.1;
    endtask

    // called at posedge+1 with inputs set; ends at next posedge+1
    task automatic tick();
        bit carry;
        check("R7 ripple high in high phase", rp_lo, 1);
        #2;
        check("R6 term lo", tc_lo, tc_of(m_lo, dir_dn, 10));
        check("R6 term bin", tc_bin, tc_of(m_bin, dir_dn, 16));
        check("R7 ripple lo", rp_lo, !(tc_of(m_lo, dir_dn, 10) && !cnt_en_n));
        check("R7 ripple bin", rp_bin, !(tc_of(m_bin, dir_dn, 16) && !cnt_en_n));
        carry = tc_of(m_lo, dir_dn, 10) && !cnt_en_n;
        if (!cnt_en_n) begin
            m_lo  = nxt(m_lo, dir_dn, 10);
            m_bin = nxt(m_bin, dir_dn, 16);
        end
        if (carry) m_hi = nxt(m_hi, dir_dn, 10);
        @(posedge clk); #1;
        check_q(cnt_en_n ? "R1 hold" : (dir_dn ? "R3/R5/R9 down step" : "R2/R5/R9 up step"));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0de5));
        @(posedge clk); #1;

        // initial preset: decimal 7 / 0, binary 13
        cnt_en_n = 1'b1;
        do_load(7, 0, 13);
        check_q("R4 initial preset");

        // R5 / R2 sequence upward
        cnt_en_n = 1'b0; dir_dn = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        check("R5 up 7->2", q_lo, 2);
        check("R2 binary 13->2", q_bin, 2);
        check("R9 carry into upper stage", q_hi, 1);

        // inhibit
        cnt_en_n = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        check("R1 inhibit keeps 2", q_lo, 2);

        // R5 / R3 sequence downward
        cnt_en_n = 1'b0; dir_dn = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        check("R5 down 2->7", q_lo, 7);
        check("R3 binary 2->13", q_bin, 13);
        check("R9 borrow from upper stage", q_hi, 0);

        // R6: direction change moves term without an edge
        cnt_en_n = 1'b1;
        do_load(0, 3, 15);
        dir_dn = 1'b1; #0.3;
        check("R6 term down at 0", tc_lo, 1);
        check("R6 term bin down at 15", tc_bin, 0);
        dir_dn = 1'b0; #0.3;
        check("R6 term up at 0", tc_lo, 0);
        check("R6 term bin up at 15", tc_bin, 1);
        #0.4;
        tick();

        // R4: load held over a rising edge wins over counting
        cnt_en_n = 1'b0; dir_dn = 1'b0;
        din_lo = 4'd4; din_hi = 4'd6; din_bin = 4'd9;
        load_n = 1'b0;
        @(posedge clk); #1;
        m_lo = 4; m_hi = 6; m_bin = 9;
        check_q("R4 load overrides count");
        load_n = 1'b1;
        tick();
        check("R4 counting resumes", q_lo, 5);

        // R4: load in the low phase, enable off so no cascade clock
        cnt_en_n = 1'b1;
        #2;
        din_lo = 4'd8; din_hi = 4'd2; din_bin = 4'd1;
        load_n = 1'b0; #0.3;
        m_lo = 8; m_hi = 2; m_bin = 1;
        check_q("R4 load during low clock phase");
        load_n = 1'b1;
        @(posedge clk); #1;
        check_q("R4 load value kept");

        // R8: out-of-range decimal recovery
        do_load(12, 0, 12);
        cnt_en_n = 1'b0; dir_dn = 1'b0;
        tick();
        check("R8 12 up -> 0", q_lo, 0);
        cnt_en_n = 1'b1;
        do_load(14, 0, 14);
        cnt_en_n = 1'b0; dir_dn = 1'b1;
        tick();
        check("R8 14 down -> 13", q_lo, 13);
        tick(); tick(); tick(); tick();
        check("R8 reaches 9", q_lo, 9);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 4) begin
                cnt_en_n = 1'b1;
                do_load(int'($urandom_range(0, 15)), int'($urandom_range(0, 9)),
                        int'($urandom_range(0, 15)));
            end
            cnt_en_n = ($urandom_range(0, 4) == 0);
            dir_dn   = ($urandom_range(0, 2) == 0);
            tick();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule